// File: doc/BRIEF.md
# Three-Wire Bit-Serial Bus Master

This block is the master side of a simple serial bus with four pins: a chip enable, a clock that idles low, a separate read/write direction line, and one bidirectional data line. The block drives the data line's output value and its output enable; the pad itself lives outside. Each transfer is either a read or a write, and its length is counted in bits. The length need not be a multiple of eight, so the last byte of a transfer may be only partly used. Bits move least significant first.

A host starts a transfer with a one-cycle `start` pulse, a direction flag and a bit count. For a write, the block pulls each byte from a valid/ready input stream at the point where the first bit of that byte is needed. It holds the bus clock low for as long as the byte is missing. For a read, it delivers each assembled byte as a one-cycle pulse on an output. It does this after every eighth bit, and again after a final partial byte. All bus timing comes from the system clock. Two cycle-count parameters set the timing: one for the setup intervals around the chip enable, and one for each half of the bus clock period. The block therefore runs from any system clock frequency.

Top module: `sbus3_master`

## Requirements
- R1: During and right after reset, `bus_ce`, `bus_clk`, `bus_wr`, `dat_oe`, `busy`, `done`, `in_ready` and `out_valid` are all 0.
- R2: In the cycle after `start` is accepted, `dat_oe` equals the direction (1 = write, 0 = read) while `bus_wr` is still 0. One cycle later `bus_wr` equals the direction. `bus_wr` does not change while `bus_ce` is high.
- R3: `busy` is high with `bus_ce` low for exactly 1 + `SETUP_CYC` cycles before `bus_ce` rises. On a read the first `bus_clk` rise follows exactly `SETUP_CYC` cycles after that. On a write it follows after at least `SETUP_CYC` + 2 cycles.
- R4: A transfer produces exactly `bit_len` bus clock pulses. Each pulse is high for exactly `HALF_CYC` cycles and is followed by at least `HALF_CYC` low cycles. `bus_clk` is high only while `bus_ce` is high.
- R5: On a write, bit i of the transfer is bit (i mod 8) of stream byte i/8. `dat_o` does not change in any cycle in which `bus_clk` is high. Exactly ceil(`bit_len`/8) bytes are taken from the input stream. `in_ready` is high only while `bus_clk` is low, and the clock stays low until the byte is supplied.
- R6: On a read, the data line is sampled in the last high cycle of each pulse. Bit i of the transfer lands in bit (i mod 8) of output byte i/8. Unused upper bits of a final partial byte are 0. Exactly ceil(`bit_len`/8) `out_valid` pulses occur, and `dat_oe` is 0 whenever `out_valid` is high.
- R7: `busy` stays high from the cycle after `start` until `bus_ce` has dropped. `done` is a one-cycle pulse in the first cycle with `bus_ce` and `busy` both low. `moved_bits` then equals `bit_len`.
- R8: A `start` pulse while `busy` is high is ignored. The running transfer completes with its own direction and length, and no second transfer follows.
- R9: A `bit_len` of 0 still frames the bus with `bus_ce`, but produces no clock pulse, and reports `moved_bits` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| dir_wr | input | 1 | Transfer direction, 1 = write, 0 = read |
| bit_len | input | LEN_W | Transfer length in bits |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| moved_bits | output | LEN_W | Bits moved by the last transfer |
| in_data | input | 8 | Write byte from host |
| in_valid | input | 1 | Write byte available |
| in_ready | output | 1 | Block takes the write byte |
| out_data | output | 8 | Read byte to host |
| out_valid | output | 1 | One-cycle read byte strobe |
| bus_ce | output | 1 | Bus chip enable |
| bus_clk | output | 1 | Bus clock, idles low |
| bus_wr | output | 1 | Bus direction line |
| dat_o | output | 1 | Data line output value |
| dat_oe | output | 1 | Data line output enable |
| dat_i | input | 1 | Data line input value |

## Verification
On a read, the end of a byte and the end of the transfer fall on the same sampled bit whenever the length is a multiple of eight. The same can happen for a write's byte fetch and the final clock pulse. The sweep covers every length from 0 to 20 in both directions, plus 27, 33 and 16. This makes the byte boundary and the last bit coincide at 8 and 16, and miss each other at the other lengths. The bench judges the result by counting `out_valid` pulses and stream handshakes against ceil(len/8), and by comparing each byte with values it computes itself, including zeroed upper bits. A stalled input stream and a `start` pulse during a transfer are layered on top, to show that the clock waits and that the length is not disturbed.

// File: rtl/sbus3_master.sv
module sbus3_master #(
  parameter int SETUP_CYC = 125,
  parameter int HALF_CYC  = 1250,
  parameter int LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_wr,
  input  logic [LEN_W-1:0] bit_len,
  output logic             busy,
  output logic             done,
  output logic [LEN_W-1:0] moved_bits,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       out_data,
  output logic             out_valid,
  output logic             bus_ce,
  output logic             bus_clk,
  output logic             bus_wr,
  output logic             dat_o,
  output logic             dat_oe,
  input  logic             dat_i
);
  // HALF_CYC must be at least 2 so a new write bit never moves on a rising clock edge.
  localparam int CMAX = (SETUP_CYC > HALF_CYC) ? SETUP_CYC : HALF_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DIR, S_WRSET, S_CEHOLD, S_FETCH, S_SETTLE, S_HIGH, S_LOW, S_END
  } st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [LEN_W-1:0] len_q, nbit;
  logic             dir_q;
  logic [7:0]       sh, acc;

  wire            in_bit   = (st == S_HIGH) || (st == S_LOW);
  wire [CW-1:0]   lim      = in_bit ? CW'(HALF_CYC - 1) : CW'(SETUP_CYC - 1);
  wire            tick     = (cnt == lim);
  wire [2:0]      bpos     = nbit[2:0];
  wire            last_bit = ((nbit + LEN_W'(1)) == len_q);
  wire [7:0]      acc_nx   = acc | ({7'd0, dat_i} << bpos);

  assign busy     = (st != S_IDLE);
  assign in_ready = (st == S_FETCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; len_q <= '0; nbit <= '0; dir_q <= 1'b0;
      sh <= '0; acc <= '0; done <= 1'b0; moved_bits <= '0;
      out_data <= '0; out_valid <= 1'b0;
      bus_ce <= 1'b0; bus_clk <= 1'b0; bus_wr <= 1'b0; dat_o <= 1'b0; dat_oe <= 1'b0;
    end else begin
      done      <= 1'b0;
      out_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (start) begin
            dir_q  <= dir_wr;
            len_q  <= bit_len;
            nbit   <= '0;
            acc    <= '0;
            dat_o  <= 1'b0;
            dat_oe <= dir_wr;
            st     <= S_DIR;
          end
        end
        S_DIR: begin
          bus_wr <= dir_q;
          cnt    <= '0;
          st     <= S_WRSET;
        end
        S_WRSET: begin
          if (tick) begin
            bus_ce <= 1'b1;
            cnt    <= '0;
            st     <= S_CEHOLD;
          end else cnt <= cnt + 1'b1;
        end
        S_CEHOLD: begin
          if (tick) begin
            cnt <= '0;
            if (len_q == '0) st <= S_END;
            else if (dir_q) st <= S_FETCH;
            else begin
              bus_clk <= 1'b1;
              st      <= S_HIGH;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_FETCH: begin
          if (in_valid) begin
            sh    <= in_data;
            dat_o <= in_data[0];
            st    <= S_SETTLE;
          end
        end
        S_SETTLE: begin
          bus_clk <= 1'b1;
          cnt     <= '0;
          st      <= S_HIGH;
        end
        S_HIGH: begin
          if (tick) begin
            bus_clk <= 1'b0;
            cnt     <= '0;
            nbit    <= nbit + 1'b1;
            st      <= S_LOW;
            if (!dir_q) begin
              if (bpos == 3'd7 || last_bit) begin
                out_data  <= acc_nx;
                out_valid <= 1'b1;
                acc       <= '0;
              end else acc <= acc_nx;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_LOW: begin
          if (cnt == '0 && dir_q) begin
            sh    <= sh >> 1;
            dat_o <= sh[1];
          end
          if (tick) begin
            cnt <= '0;
            if (nbit == len_q) st <= S_END;
            else if (dir_q && bpos == 3'd0) st <= S_FETCH;
            else begin
              bus_clk <= 1'b1;
              st      <= S_HIGH;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_END: begin
          bus_ce     <= 1'b0;
          bus_wr     <= 1'b0;
          dat_oe     <= 1'b0;
          dat_o      <= 1'b0;
          done       <= 1'b1;
          moved_bits <= nbit;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_clk_inside_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clk |-> bus_ce);
  assert_data_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clk |-> $stable(dat_o));
  assert_ready_clk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !bus_clk);
  assert_wr_fixed_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ce && $past(bus_ce)) |-> $stable(bus_wr));
  assert_read_strobe_undriven_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !dat_oe);
  assert_done_after_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_ce && !busy));
  assert_start_busy_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && bus_ce) |=> (busy || done));
endmodule

// File: tb/sim_sbus3_master.sv
module sim_sbus3_master;
  localparam int SU = 3;
  localparam int HC = 3;
  localparam int LW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, start, dir_wr, busy, done, in_valid, in_ready, out_valid;
  logic [LW-1:0] bit_len, moved_bits;
  logic [7:0]    in_data, out_data;
  logic          bus_ce, bus_clk, bus_wr, dat_o, dat_oe, dat_i;

  sbus3_master #(.SETUP_CYC(SU), .HALF_CYC(HC), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_wr(dir_wr), .bit_len(bit_len),
    .busy(busy), .done(done), .moved_bits(moved_bits),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid),
    .bus_ce(bus_ce), .bus_clk(bus_clk), .bus_wr(bus_wr),
    .dat_o(dat_o), .dat_oe(dat_oe), .dat_i(dat_i));

  int errors = 0, checks = 0;

  function automatic logic [7:0] wbyte(int len, int k);
    return 8'((k * 37 + len * 11 + 5) & 255);
  endfunction
  function automatic logic rbit(int len, int i);
    return logic'(((i * 5 + len * 3) % 7) > 2);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int cur_len = 0, in_idx = 0, gap = 0, stall = 0, rd_n = 0;
  bit feeding = 0, hs_pending = 0;
  assign in_data = wbyte(cur_len, in_idx);
  assign dat_i   = rbit(cur_len, rd_n);

  int pulses, hi_run, lo_run, hibad, lowbad, pre_ce, pre_clk, rx_n;
  bit seen_ce, prev_bclk;
  logic cap [0:63];
  logic [7:0] rx [0:15];

  always @(negedge clk) begin
    if (bus_clk && !prev_bclk) begin
      if (bus_wr) cap[pulses] = dat_o;
      if (pulses > 0 && lo_run < HC) lowbad++;
      pulses++;
      hi_run = 1;
    end else if (bus_clk) hi_run++;
    if (!bus_clk && prev_bclk) begin
      if (hi_run != HC) hibad++;
      rd_n++;
      lo_run = 1;
    end else if (!bus_clk) lo_run++;
    if (bus_ce) seen_ce = 1;
    if (busy && !bus_ce && !seen_ce) pre_ce++;
    if (bus_ce && pulses == 0 && !bus_clk) pre_clk++;
    if (out_valid) begin rx[rx_n] = out_data; rx_n++; end
    prev_bclk = bus_clk;
    if (hs_pending) begin
      in_idx++; in_valid = 0; gap = stall; hs_pending = 0;
    end else if (in_valid && in_ready) hs_pending = 1;
    else if (!in_valid && feeding) begin
      if (gap > 0) gap--; else in_valid = 1;
    end
  end

  task automatic run(input bit dir, input int len, input int stl, input bit poke);
    int t, mism, bad_i, nb;
    logic [7:0] e;
    string lreq;
    cur_len = len; stall = stl; gap = stl; in_idx = 0; in_valid = 0; hs_pending = 0;
    feeding = dir; rd_n = 0;
    pulses = 0; hi_run = 0; lo_run = 0; hibad = 0; lowbad = 0; pre_ce = 0; pre_clk = 0;
    rx_n = 0; seen_ce = 0;
    @(negedge clk); start = 1; dir_wr = dir; bit_len = LW'(len);
    @(negedge clk); start = 0;
    chk(busy == 1, "R7", "busy after start", busy, 1);
    chk(dat_oe == dir, "R2", "oe before wr", dat_oe, dir);
    chk(bus_wr == 0, "R2", "wr not yet driven", bus_wr, 0);
    @(negedge clk);
    chk(bus_wr == dir, "R2", "wr driven", bus_wr, dir);
    if (poke) begin
      repeat (4) @(negedge clk);
      start = 1; dir_wr = !dir; bit_len = LW'(len + 3);
      @(negedge clk); start = 0;
    end
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    lreq = (len == 0) ? "R9" : "R7";
    chk(done == 1, "R7", "done pulse", done, 1);
    chk(!bus_ce && !busy, "R7", "ce and busy low at done", {bus_ce, busy}, 0);
    chk(moved_bits == LW'(len), lreq, "moved_bits", moved_bits, len);
    chk(pulses == len, (len == 0) ? "R9" : "R4", "clock pulses", pulses, len);
    chk(hibad == 0 && lowbad == 0, "R4", "pulse widths", hibad + lowbad, 0);
    chk(pre_ce == 1 + SU, "R3", "cycles before ce", pre_ce, 1 + SU);
    if (len > 0) begin
      if (!dir) chk(pre_clk == SU, "R3", "ce to first clk (read)", pre_clk, SU);
      else chk(pre_clk >= SU + 2, "R3", "ce to first clk (write)", pre_clk, SU + 2);
    end
    nb = (len + 7) / 8;
    if (dir) begin
      mism = 0; bad_i = 0;
      for (int i = 0; i < len; i++)
        if (cap[i] !== wbyte(len, i / 8)[i % 8]) begin mism++; bad_i = i; end
      chk(mism == 0, "R5", "written bits wrong", mism, 0);
      chk(in_idx == nb, "R5", "bytes fetched", in_idx, nb);
    end else begin
      chk(rx_n == nb, "R6", "read bytes", rx_n, nb);
      for (int k = 0; k < nb && k < rx_n; k++) begin
        e = 8'd0;
        for (int j = 0; j < 8; j++) if (8 * k + j < len) e[j] = rbit(len, 8 * k + j);
        chk(rx[k] == e, "R6", "read byte value", rx[k], e);
      end
    end
    @(negedge clk);
    chk(done == 0, "R7", "done one cycle", done, 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(busy == 0 && pulses == len, "R8", "start while busy ignored", pulses, len);
    end
    feeding = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 0; start = 0; dir_wr = 0; bit_len = '0; in_valid = 0;
    repeat (3) @(negedge clk);
    chk({bus_ce, bus_clk, bus_wr, dat_oe} == 4'b0, "R1", "bus lines in reset",
        {bus_ce, bus_clk, bus_wr, dat_oe}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({busy, done, in_ready, out_valid} == 4'b0, "R1", "status after reset",
        {busy, done, in_ready, out_valid}, 0);
    chk(bus_clk == 0 && bus_ce == 0, "R1", "clk idle low", bus_clk, 0);
    for (int d = 0; d < 2; d++)
      for (int n = 0; n <= 20; n++)
        run(d[0], n, n % 3, 0);
    run(1'b1, 33, 2, 1);
    run(1'b0, 27, 0, 1);
    run(1'b0, 16, 0, 0);
    run(1'b1, 16, 4, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule